// File: doc/BRIEF.md
# Addressed DAC Frame Receiver

This block terminates the regulator end of an isolated synchronous serial command link. The sender lowers an active-low frame strobe and clocks in 51 bits. The first 3 bits pick a destination, and the next 48 bits are four 12-bit channel codes. The strobe, the serial clock, the data and the cable-present input all cross into the local clock domain through two-flop synchronizers. A serial-clock rising edge is recognised from the synchronized samples.

The incoming bits are collected in a shadow shift register. When the strobe returns high, a frame of exactly the right length is decoded:

- A frame addressed to a local DAC group loads all four channel registers of that group in one cycle.
- A frame carrying the detector-board code is copied out, bit for bit, on a downstream serial port.
- A frame carrying a code with no assignment changes nothing and sets a sticky error flag.

The block also watches the link. If the cable-present input drops, or if the serial clock stops for a programmable number of cycles in the middle of a frame, every DAC code is forced to zero. A frame cut short by a stalled clock is thrown away.

Top module: `dac_frame_rx`

## Requirements
- R1: A frame holds 51 bits taken on serial-clock rising edges. The first 3 bits are the destination code, most significant bit first. Four 12-bit channel codes follow, each most significant bit first. The first channel sent is channel 0, which appears at `dac_codes[(g*4+c)*12 +: 12]` for group g and channel c.
- R2: A valid frame for group g (code 0 to 4) writes all four of that group's channels together. The write takes effect on the third rising edge of `clk` after `fs_n` rises. All other groups keep their values.
- R3: A frame with any bit count other than 51 when `fs_n` rises is discarded, and no output changes.
- R4: A valid frame with code 7 leaves every local group unchanged. The same 51 bits are retransmitted in the same order on the downstream port. `dn_fs_n` is held low for the whole transfer, and each bit is valid at a rising edge of `dn_sclk`.
- R5: A valid frame with code 5 or 6 changes no channel and sets `dest_err`, which stays set until reset.
- R6: While `cable_ok` is low, all DAC codes read zero from the third `clk` edge after it falls, and frames are ignored.
- R7: If no serial-clock rising edge arrives for `idle_limit` clock cycles while `fs_n` is low, all DAC codes go to zero. The frame in progress is then discarded.
- R8: After reset, all DAC codes are zero, `dest_err` is 0, `dn_fs_n` is 1 and `dn_sclk` is 0.
- R9: Serial-clock edges that occur while `fs_n` is high do not shift data into the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Upstream serial clock |
| sdi | input | 1 | Upstream serial data |
| fs_n | input | 1 | Upstream frame strobe, active low |
| cable_ok | input | 1 | High while the upstream cable is present |
| idle_limit | input | 16 | Serial-clock idle timeout in clock cycles |
| dac_codes | output | 240 | Five groups of four 12-bit channel codes |
| dest_err | output | 1 | Sticky flag for an unassigned destination |
| dn_sclk | output | 1 | Downstream serial clock |
| dn_sdo | output | 1 | Downstream serial data |
| dn_fs_n | output | 1 | Downstream frame strobe, active low |

## Verification
A channel update and a `dest_err` change are due on the third `clk` rising edge after the stimulus. For a frame, the stimulus is the rise of `fs_n`; for a cable drop, it is the fall of `cable_ok`. The scoreboard stores each expected result together with that due cycle. The monitor checks the previous image one cycle before the due cycle and the new image on it, so both an early and a late update are caught. Relayed frames have no fixed latency, so the monitor rebuilds each one from the downstream port and compares it when `dn_fs_n` returns high. The idle-timeout result is checked after a pause well past `idle_limit`.

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int NGRP     = 5,
  parameter int NCH      = 4,
  parameter int CW       = 12,
  parameter int DW       = 3,
  parameter int TW       = 16,
  parameter int DET_CODE = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic                      fs_n,
  input  logic                      cable_ok,
  input  logic [TW-1:0]             idle_limit,
  output logic [NGRP*NCH*CW-1:0]    dac_codes,
  output logic                      dest_err,
  output logic                      dn_sclk,
  output logic                      dn_sdo,
  output logic                      dn_fs_n
);
  localparam int BW   = NCH * CW;
  localparam int FLEN = DW + BW;
  localparam int CNTW = $clog2(FLEN + 2);
  localparam logic [CNTW-1:0] CMAX = '1;
  localparam logic [CNTW-1:0] CFULL = CNTW'(FLEN);
  localparam logic [DW-1:0] DET = DW'(DET_CODE);

  logic [2:0] sclk_q, fs_q;
  logic [1:0] sdi_q, cab_q;
  logic [FLEN-1:0] sh;
  logic [CNTW-1:0] cnt;
  logic [TW-1:0] idle_cnt;
  logic abort;
  logic [BW-1:0] bank [NGRP];
  logic [FLEN-1:0] rbuf;
  logic busy, ph;
  logic [CNTW-1:0] ridx;
  logic cable_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      fs_q   <= '1;
      sdi_q  <= '0;
      cab_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      fs_q   <= {fs_q[1:0], fs_n};
      sdi_q  <= {sdi_q[0], sdi};
      cab_q  <= {cab_q[0], cable_ok};
    end

  assign cable_s2 = cab_q[1];
  wire fs_act  = ~fs_q[1];
  wire rise    = sclk_q[1] & ~sclk_q[2];
  wire fin     = fs_q[1] & ~fs_q[2];
  wire timeout = fs_act & ~abort & ~rise & (idle_cnt == idle_limit - 1'b1);
  wire zap     = ~cable_s2 | timeout;
  wire fin_ok  = fin & (cnt == CFULL) & ~abort & cable_s2;
  wire [DW-1:0] dest = sh[FLEN-1 -: DW];
  wire local_hit = (32'(dest) < NGRP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0;
      cnt <= '0;
      idle_cnt <= '0;
      abort <= 1'b0;
    end else if (!fs_act) begin
      cnt <= '0;
      idle_cnt <= '0;
      abort <= 1'b0;
    end else begin
      if (rise) begin
        sh <= {sh[FLEN-2:0], sdi_q[1]};
        if (cnt != CMAX) cnt <= cnt + 1'b1;
        idle_cnt <= '0;
      end else if (!abort) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (timeout || !cable_s2) abort <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) bank[g] <= '0;
    end else if (zap) begin
      for (int g = 0; g < NGRP; g++) bank[g] <= '0;
    end else if (fin_ok) begin
      for (int g = 0; g < NGRP; g++)
        if (dest == DW'(g)) bank[g] <= sh[BW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dest_err <= 1'b0;
    else if (fin_ok && !local_hit && dest != DET) dest_err <= 1'b1;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign dac_codes[(g*NCH+c)*CW +: CW] = bank[g][(NCH-1-c)*CW +: CW];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbuf <= '0;
      busy <= 1'b0;
      ph   <= 1'b0;
      ridx <= '0;
    end else if (!busy) begin
      if (fin_ok && dest == DET) begin
        rbuf <= sh;
        busy <= 1'b1;
        ph   <= 1'b0;
        ridx <= '0;
      end
    end else begin
      ph <= ~ph;
      if (ph) begin
        rbuf <= {rbuf[FLEN-2:0], 1'b0};
        ridx <= ridx + 1'b1;
        if (ridx == CNTW'(FLEN - 1)) busy <= 1'b0;
      end
    end

  assign dn_sdo  = rbuf[FLEN-1];
  assign dn_sclk = busy & ph;
  assign dn_fs_n = ~busy;
endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk #(
  parameter int DACW = 240
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cable_s2,
  input logic            zap,
  input logic            fin_ok,
  input logic [DACW-1:0] dac_codes,
  input logic            dest_err,
  input logic            dn_sclk,
  input logic            dn_sdo,
  input logic            dn_fs_n
);
  // R6
  cable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cable_s2 |=> (dac_codes == '0));

  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_ok || zap) |=> $stable(dac_codes));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dest_err |=> dest_err);

  // R4
  relay_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sclk |-> $stable(dn_sdo));

  // R4
  relay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_fs_n) |-> $past(fin_ok));
endmodule

bind dac_frame_rx dac_frame_rx_chk #(.DACW(NGRP*NCH*CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cable_s2(cable_s2), .zap(zap), .fin_ok(fin_ok),
  .dac_codes(dac_codes), .dest_err(dest_err), .dn_sclk(dn_sclk),
  .dn_sdo(dn_sdo), .dn_fs_n(dn_fs_n)
);

// File: tb/dac_frame_rx_test.sv
module dac_frame_rx_test;
  localparam int IW = 240;
  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, fs_n = 1, cable_ok = 1;
  logic [15:0] idle_limit = 16'd40;
  logic [IW-1:0] dac_codes;
  logic dest_err, dn_sclk, dn_sdo, dn_fs_n;

  dac_frame_rx uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .fs_n(fs_n),
    .cable_ok(cable_ok), .idle_limit(idle_limit), .dac_codes(dac_codes),
    .dest_err(dest_err), .dn_sclk(dn_sclk), .dn_sdo(dn_sdo), .dn_fs_n(dn_fs_n));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [11:0] mdl [5][4];
  logic merr = 0;
  logic [IW-1:0] pre_q[$], post_q[$];
  logic epre_q[$], epost_q[$];
  int due_q[$];
  logic [50:0] relay_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] img();
    logic [IW-1:0] r;
    for (int g = 0; g < 5; g++)
      for (int c = 0; c < 4; c++) r[(g*4+c)*12 +: 12] = mdl[g][c];
    return r;
  endfunction

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [50:0] fr, input int nbits, input int pause_at);
    fs_n = 0;
    clk_n(2);
    for (int i = 0; i < nbits; i++) begin
      if (i == pause_at) begin
        clk_n(70);
        // R7 stalled serial clock forces zero
        chk(dac_codes == '0, "R7 idle timeout zero", dac_codes, '0);
      end
      sdi = (i < 51) ? fr[50-i] : 1'b1;
      clk_n(2);
      sclk = 1;
      clk_n(2);
      sclk = 0;
    end
    clk_n(2);
    fs_n = 1;
  endtask

  task automatic send_cmd(input logic [2:0] d, input logic [11:0] a, input logic [11:0] b,
                          input logic [11:0] c, input logic [11:0] e, input int nbits,
                          input int pause_at);
    logic [IW-1:0] p;
    logic pe;
    logic [50:0] fr;
    fr = {d, a, b, c, e};
    p = img();
    pe = merr;
    xfer(fr, nbits, pause_at);
    if (pause_at < nbits) begin
      for (int g = 0; g < 5; g++) for (int k = 0; k < 4; k++) mdl[g][k] = '0;
      p = '0;
    end else if (nbits == 51 && cable_ok) begin
      if (d < 5) begin
        mdl[d][0] = a; mdl[d][1] = b; mdl[d][2] = c; mdl[d][3] = e;
      end else if (d == 7) relay_q.push_back(fr);
      else merr = 1;
    end
    pre_q.push_back(p); post_q.push_back(img());
    epre_q.push_back(pe); epost_q.push_back(merr);
    due_q.push_back(cyc + 3);
    clk_n(8);
  endtask

  always @(negedge clk) begin
    if (due_q.size() > 0) begin
      if (cyc == due_q[0] - 1) begin
        chk(dac_codes == pre_q[0], "R2 no early update", dac_codes, pre_q[0]);
        chk(dest_err == epre_q[0], "R5 flag before due", IW'(dest_err), IW'(epre_q[0]));
      end else if (cyc == due_q[0]) begin
        chk(dac_codes == post_q[0], "R1 R2 R3 R4 R6 image at due", dac_codes, post_q[0]);
        chk(dest_err == epost_q[0], "R5 flag at due", IW'(dest_err), IW'(epost_q[0]));
        void'(due_q.pop_front()); void'(pre_q.pop_front()); void'(post_q.pop_front());
        void'(epre_q.pop_front()); void'(epost_q.pop_front());
      end
    end
  end

  logic prev_dsclk = 0, prev_dfs = 1;
  logic [50:0] rx_word;
  int rx_cnt = 0;
  always @(negedge clk) begin
    if (!dn_fs_n && dn_sclk && !prev_dsclk) begin
      rx_word = {rx_word[49:0], dn_sdo};
      rx_cnt++;
    end
    if (dn_fs_n && !prev_dfs) begin
      if (relay_q.size() == 0)
        chk(0, "R4 unexpected relay", IW'(rx_word), '0);
      else begin
        // R4 relayed frame matches
        chk(rx_cnt == 51 && rx_word == relay_q[0], "R4 relay frame", IW'(rx_word), IW'(relay_q[0]));
        void'(relay_q.pop_front());
      end
      rx_cnt = 0;
    end
    prev_dsclk = dn_sclk;
    prev_dfs = dn_fs_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int g = 0; g < 5; g++) for (int k = 0; k < 4; k++) mdl[g][k] = '0;
    clk_n(3);
    rst_n = 1;
    clk_n(4);
    // R8 reset state
    chk(dac_codes == '0, "R8 codes zero", dac_codes, '0);
    chk(dest_err == 0 && dn_fs_n == 1 && dn_sclk == 0, "R8 flags",
        IW'({dest_err, dn_fs_n, dn_sclk}), IW'(3'b010));

    send_cmd(3'd0, 12'h123, 12'h456, 12'h789, 12'hABC, 51, 999);
    send_cmd(3'd3, 12'hFFF, 12'h000, 12'h801, 12'h7FE, 51, 999);
    send_cmd(3'd4, 12'h5A5, 12'hA5A, 12'h001, 12'hF00, 51, 999);
    send_cmd(3'd0, 12'hEDC, 12'hBA9, 12'h876, 12'h543, 51, 999);
    // R3 short and long frames
    send_cmd(3'd1, 12'h111, 12'h222, 12'h333, 12'h444, 50, 999);
    send_cmd(3'd2, 12'h111, 12'h222, 12'h333, 12'h444, 52, 999);
    // R9 edges with strobe high
    for (int i = 0; i < 5; i++) begin
      sdi = 1; clk_n(2); sclk = 1; clk_n(2); sclk = 0;
    end
    send_cmd(3'd1, 12'h0F0, 12'h00F, 12'hF0F, 12'h3C3, 51, 999);
    // R4 relay
    send_cmd(3'd7, 12'hDEA, 12'hDBE, 12'hEF0, 12'h1A2, 51, 999);
    send_cmd(3'd7, 12'h000, 12'hFFF, 12'h555, 12'hAAA, 51, 999);
    // R5 unassigned codes
    send_cmd(3'd5, 12'h999, 12'h999, 12'h999, 12'h999, 51, 999);
    send_cmd(3'd6, 12'h777, 12'h777, 12'h777, 12'h777, 51, 999);
    // R7 idle timeout mid-frame
    send_cmd(3'd2, 12'h321, 12'h654, 12'h987, 12'hCBA, 51, 20);
    send_cmd(3'd2, 12'h321, 12'h654, 12'h987, 12'hCBA, 51, 999);
    // R6 cable loss
    cable_ok = 0;
    pre_q.push_back(img());
    for (int g = 0; g < 5; g++) for (int k = 0; k < 4; k++) mdl[g][k] = '0;
    post_q.push_back(img());
    epre_q.push_back(merr); epost_q.push_back(merr);
    due_q.push_back(cyc + 3);
    clk_n(8);
    send_cmd(3'd1, 12'hABA, 12'hBAB, 12'hCDC, 12'hDCD, 51, 999);
    chk(dac_codes == '0, "R6 frame ignored while cable low", dac_codes, '0);
    cable_ok = 1;
    clk_n(5);
    send_cmd(3'd3, 12'h246, 12'h8AC, 12'h135, 12'h79B, 51, 999);
    clk_n(200);
    chk(relay_q.size() == 0 && due_q.size() == 0, "R4 R2 queues drained",
        IW'(relay_q.size() + due_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule